// File: doc/BRIEF.md
# Stochastic FP32 Narrowing Converter

This block turns a single-precision floating-point word into a narrower binary float (5 exponent bits and 10 mantissa bits by default) and picks the rounding direction by chance rather than by a fixed rule. Each valid beat carries a data word and a 32-bit seed. One shift-register step turns the seed into a pseudo-random draw. The truncated mantissa is bumped by one unit in the last place when the share of the source mantissa that was cut off is at least as large as the drawn fraction. Both fractions are compared in integer form, so the block needs no divider.

The exponent is re-biased for the target format. Values below the target's normal range become subnormals by shifting right. Values beyond its range saturate to infinity. NaN, infinity and zero pass through as the matching target codes and keep their sign. The block holds no state from one conversion to the next: the same word and seed always give the same result. The result is registered and appears one cycle after the input beat.

Top module: `fp32_sr_narrow`

## Requirements
- R1: An input beat with `in_valid` high at a rising edge gives `out_valid` high, with the converted word on `out_word`, after that edge. A cycle without an input beat gives `out_valid` low after the edge.
- R2: Synchronous active-high reset clears `out_valid` and `out_word` to zero. A cycle without an input beat leaves `out_word` unchanged, whatever `in_word` and `in_seed` hold.
- R3: The draw is computed from seed x as follows. Shift x right by one place. Form the feedback bit x[0]^x[1]^x[3]^x[12] and OR it into bit 15 of the shifted value.
- R4: The sign of the result (output bit 15 by default) always equals bit 31 of the input word.
- R5: A NaN input (exponent all ones, mantissa nonzero) gives an all-ones exponent with only the top mantissa bit set (0x7E00 or 0xFE00). An infinite input gives an all-ones exponent with a zero mantissa (0x7C00 or 0xFC00). A zero input of either sign gives a zero of that sign. None of these is ever rounded, for any seed.
- R6: A finite input whose re-biased exponent (source exponent - 127 + 15) reaches 31 or more gives infinity of the same sign.
- R7: For a re-biased exponent from 1 to 30, the result exponent equals the re-biased exponent. Before rounding, the result mantissa is the top 10 bits of the 23-bit source mantissa.
- R8: For a re-biased exponent e below 1, the result exponent is 0. Before rounding, the mantissa is the 11-bit significand (hidden one included when the source exponent is nonzero) shifted right by 1-e, and it is zero when 1-e exceeds 10.
- R9: The discarded field D is the low 13 bits of the source mantissa, and the draw L comes from R3. The result is rounded up exactly when D*(2^32-1) >= L*(2^23-1). A draw of zero therefore always rounds up, even when D is zero.
- R10: Rounding up an all-ones mantissa clears it and adds one to the exponent. This carries the largest subnormal into the smallest normal, and the largest finite value into infinity. The exponent is never incremented past all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat qualifier |
| in_word | input | 32 | Single-precision source value |
| in_seed | input | 32 | Seed for the rounding draw of this beat |
| out_valid | output | 1 | Result qualifier, one cycle after the beat |
| out_word | output | 16 | Converted value (sign, 5-bit exponent, 10-bit mantissa) |

## Verification
The assertions assume that `in_valid` is low while reset is held. They also assume that `in_word` and `in_seed` carry known values in every cycle with `in_valid` high, because the sign and infinity checks compare against the sampled input word. The stimulus drives every input on the falling clock edge, keeps `in_valid` low through reset, and keeps the data inputs defined at all times. The idle-hold case deliberately changes the data inputs while `in_valid` is low, to show that the output is left alone.

// File: rtl/sr_pkg.sv
package sr_pkg;

    localparam int SRC_EXP_W = 8;
    localparam int SRC_MAN_W = 23;
    localparam int SRC_BIAS  = 127;
    localparam int DRAW_W    = 32;
    localparam int FB_POS    = 15;

    typedef struct packed {
        logic                 sign;
        logic [SRC_EXP_W-1:0] exp;
        logic [SRC_MAN_W-1:0] man;
    } fp32_t;

    typedef enum logic [1:0] {
        K_ZERO = 2'd0,
        K_NUM  = 2'd1,
        K_INF  = 2'd2,
        K_NAN  = 2'd3
    } kind_e;

    function automatic kind_e classify(input fp32_t v);
        if (v.exp == '1)
            return (v.man == '0) ? K_INF : K_NAN;
        else if (v.exp == '0 && v.man == '0)
            return K_ZERO;
        else
            return K_NUM;
    endfunction

endpackage

// File: rtl/sr_lfsr_step.sv
module sr_lfsr_step #(
    parameter int W = sr_pkg::DRAW_W
) (
    input  logic [W-1:0] seed,
    output logic [W-1:0] draw
);
    localparam int FBP = sr_pkg::FB_POS;

    logic fb;

    always_comb begin
        fb   = seed[0] ^ seed[1] ^ seed[3] ^ seed[12];
        draw = seed >> 1;
        draw[FBP] = draw[FBP] | fb;
    end

endmodule

// File: rtl/sr_draw_compare.sv
module sr_draw_compare #(
    parameter int DISC_W = 13,
    parameter int MAN_W  = sr_pkg::SRC_MAN_W,
    parameter int DRAW_W = sr_pkg::DRAW_W
) (
    input  logic [DISC_W-1:0] disc,
    input  logic [DRAW_W-1:0] draw,
    output logic              round_up
);
    localparam int PW = DRAW_W + MAN_W + 1;
    localparam logic [PW-1:0] DRAW_MAX = PW'({DRAW_W{1'b1}});
    localparam logic [PW-1:0] MAN_MAX  = PW'({MAN_W{1'b1}});

    logic [PW-1:0] lhs;
    logic [PW-1:0] rhs;

    always_comb begin
        lhs      = PW'(disc) * DRAW_MAX;
        rhs      = PW'(draw) * MAN_MAX;
        round_up = (lhs >= rhs);
    end

    always_comb begin
        if (draw == '0)
            AST_ZERO_DRAW_ROUNDS: assert (round_up); // R9
    end

endmodule

// File: rtl/sr_rebias.sv
module sr_rebias
    import sr_pkg::*;
#(
    parameter int DE = 5,
    parameter int DM = 10
) (
    input  fp32_t           src,
    output kind_e           kind,
    output logic            sat,
    output logic [DE-1:0]   t_exp,
    output logic [DM-1:0]   t_man,
    output logic [SRC_MAN_W-DM-1:0] disc
);
    localparam int DROP      = SRC_MAN_W - DM;
    localparam int DST_BIAS  = (2 ** (DE - 1)) - 1;
    localparam int EXP_ONES  = (2 ** DE) - 1;

    logic [SRC_MAN_W:0] full;
    logic [DM:0]        sig;
    logic [DM:0]        shifted;
    int                 e_i;
    int                 sh_i;

    always_comb begin
        kind    = classify(src);
        full    = {(src.exp != '0), src.man};
        sig     = full[SRC_MAN_W:DROP];
        disc    = src.man[DROP-1:0];
        e_i     = int'(src.exp) - SRC_BIAS + DST_BIAS;
        sh_i    = 1 - e_i;
        sat     = 1'b0;
        t_exp   = '0;
        t_man   = '0;
        shifted = '0;
        if (e_i >= EXP_ONES) begin
            sat = 1'b1;
        end else if (e_i >= 1) begin
            t_exp = DE'(e_i);
            t_man = sig[DM-1:0];
        end else if (sh_i <= DM) begin
            shifted = sig >> sh_i;
            t_man   = shifted[DM-1:0];
        end
    end

endmodule

// File: rtl/sr_pack_result.sv
module sr_pack_result
    import sr_pkg::*;
#(
    parameter int DE = 5,
    parameter int DM = 10
) (
    input  kind_e           kind,
    input  logic            sign,
    input  logic            sat,
    input  logic [DE-1:0]   t_exp,
    input  logic [DM-1:0]   t_man,
    input  logic            round_up,
    output logic [DE+DM:0]  word
);
    logic [DE-1:0] r_exp;
    logic [DM-1:0] r_man;

    always_comb begin
        r_exp = t_exp;
        r_man = t_man;
        if (round_up) begin
            if (t_man == '1) begin
                r_man = '0;
                if (t_exp != '1)
                    r_exp = t_exp + 1'b1;
            end else begin
                r_man = t_man + 1'b1;
            end
        end
        unique case (kind)
            K_NAN:  word = {sign, {DE{1'b1}}, 1'b1, {(DM-1){1'b0}}};
            K_INF:  word = {sign, {DE{1'b1}}, {DM{1'b0}}};
            K_ZERO: word = {sign, {(DE+DM){1'b0}}};
            default: begin
                if (sat)
                    word = {sign, {DE{1'b1}}, {DM{1'b0}}};
                else
                    word = {sign, r_exp, r_man};
            end
        endcase
    end

endmodule

// File: rtl/fp32_sr_narrow.sv
module fp32_sr_narrow
    import sr_pkg::*;
#(
    parameter int DST_EXP_W = 5,
    parameter int DST_MAN_W = 10
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         in_valid,
    input  logic [31:0]                  in_word,
    input  logic [31:0]                  in_seed,
    output logic                         out_valid,
    output logic [DST_EXP_W+DST_MAN_W:0] out_word
);
    localparam int DW   = DST_EXP_W + DST_MAN_W + 1;
    localparam int DROP = SRC_MAN_W - DST_MAN_W;

    fp32_t                 src;
    kind_e                 kind;
    logic                  sat;
    logic [DST_EXP_W-1:0]  t_exp;
    logic [DST_MAN_W-1:0]  t_man;
    logic [DROP-1:0]       disc;
    logic [DRAW_W-1:0]     draw;
    logic                  bump;
    logic                  round_up;
    logic [DW-1:0]         word_d;

    assign src = fp32_t'(in_word);

    sr_lfsr_step #(.W(DRAW_W)) u_draw (
        .seed (in_seed),
        .draw (draw)
    );

    sr_rebias #(.DE(DST_EXP_W), .DM(DST_MAN_W)) u_rebias (
        .src   (src),
        .kind  (kind),
        .sat   (sat),
        .t_exp (t_exp),
        .t_man (t_man),
        .disc  (disc)
    );

    sr_draw_compare #(.DISC_W(DROP), .MAN_W(SRC_MAN_W), .DRAW_W(DRAW_W)) u_cmp (
        .disc     (disc),
        .draw     (draw),
        .round_up (bump)
    );

    assign round_up = bump && (kind == K_NUM) && !sat;

    sr_pack_result #(.DE(DST_EXP_W), .DM(DST_MAN_W)) u_pack (
        .kind     (kind),
        .sign     (src.sign),
        .sat      (sat),
        .t_exp    (t_exp),
        .t_man    (t_man),
        .round_up (round_up),
        .word     (word_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_word  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                out_word <= word_d;
        end
    end

    AST_OUT_PIPE: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R1

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_word))); // R2

    AST_SIGN_KEPT: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_word[DW-1] == $past(in_word[31]))); // R4

    AST_INF_CLEAN: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_word[30:0] == 31'h7F80_0000)
        |=> (out_word[DW-2:0] == {{DST_EXP_W{1'b1}}, {DST_MAN_W{1'b0}}})); // R5

endmodule

// File: tb/fp32_sr_narrow_tb_top.sv
`timescale 1ns/1ps
module fp32_sr_narrow_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic [31:0] in_seed = '0;
    logic        out_valid;
    logic [15:0] out_word;
    logic [31:0] ls = '0;
    logic [31:0] ld;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    localparam logic [31:0] SEED_ONE  = 32'h0000_0001; // draw 0x8000
    localparam logic [31:0] SEED_BIG  = 32'hFFFF_FFFF; // draw 0x7FFFFFFF
    localparam logic [31:0] SEED_ZERO = 32'h0000_0000; // draw 0

    always #10 clk = ~clk;

    fp32_sr_narrow dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_word   (in_word),
        .in_seed   (in_seed),
        .out_valid (out_valid),
        .out_word  (out_word)
    );

    sr_lfsr_step #(.W(32)) lfsr_u (.seed(ls), .draw(ld));

    function automatic logic [31:0] ref_draw(input logic [31:0] x);
        logic [31:0] r;
        r = x >> 1;
        r[15] = r[15] | (x[0] ^ x[1] ^ x[3] ^ x[12]);
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic convert(input string req, input logic [31:0] w,
                           input logic [31:0] s, input logic [15:0] exp);
        @(negedge clk);
        in_valid = 1'b1; in_word = w; in_seed = s;
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " valid"}, {31'b0, out_valid}, 32'd1);
        check(req, {16'b0, out_word}, {16'b0, exp});
    endtask

    task automatic t_reset;
        check("R2 reset valid", {31'b0, out_valid}, 32'd0);
        check("R2 reset word", {16'b0, out_word}, 32'd0);
    endtask

    task automatic t_lfsr;
        logic [31:0] seeds [6] = '{32'h1, 32'h2, 32'h1000, 32'hFFFF_FFFF, 32'h8, 32'hDEAD_BEEF};
        foreach (seeds[i]) begin
            ls = seeds[i];
            #1;
            check("R3 draw", ld, ref_draw(seeds[i]));
        end
        ls = 32'h1;          #1; check("R3 draw of 1", ld, 32'h0000_8000);
        ls = 32'hFFFF_FFFF;  #1; check("R3 draw of ones", ld, 32'h7FFF_FFFF);
    endtask

    task automatic t_normal;
        convert("R7 one", 32'h3F80_0000, SEED_ONE, 16'h3C00);
        convert("R7 pi truncate", 32'h4049_0FDB, SEED_BIG, 16'h4248);
        convert("R9 pi round", 32'h4049_0FDB, SEED_ONE, 16'h4249);
        convert("R4 negative one", 32'hBF80_0000, SEED_BIG, 16'hBC00);
    endtask

    task automatic t_ratio;
        convert("R9 disc 63 truncates", 32'h3F80_003F, SEED_ONE, 16'h3C00);
        convert("R9 disc 64 rounds", 32'h3F80_0040, SEED_ONE, 16'h3C01);
        convert("R9 max disc big draw", 32'h3F80_1FFF, SEED_BIG, 16'h3C00);
        convert("R9 zero draw zero disc", 32'h3F80_0000, SEED_ZERO, 16'h3C01);
    endtask

    task automatic t_carry;
        convert("R10 mantissa carry", 32'h3FFF_E040, SEED_ONE, 16'h4000);
        convert("R10 max finite to inf", 32'h477F_E040, SEED_ONE, 16'h7C00);
        convert("R10 subnormal to normal", 32'h387F_E000, SEED_ZERO, 16'h0400);
    endtask

    task automatic t_subnormal;
        convert("R8 shift one", 32'h3800_0000, SEED_ONE, 16'h0200);
        convert("R8 smallest", 32'h3380_0000, SEED_ONE, 16'h0001);
        convert("R8 below range", 32'h3300_0000, SEED_ONE, 16'h0000);
        convert("R8 below range round", 32'h3300_0000, SEED_ZERO, 16'h0001);
        convert("R8 negative", 32'hB800_0000, SEED_BIG, 16'h8200);
    endtask

    task automatic t_special;
        convert("R5 nan", 32'h7FC0_0000, SEED_ZERO, 16'h7E00);
        convert("R5 neg nan", 32'hFFC0_0001, SEED_ONE, 16'hFE00);
        convert("R5 neg inf", 32'hFF80_0000, SEED_ZERO, 16'hFC00);
        convert("R5 pos inf", 32'h7F80_0000, SEED_ONE, 16'h7C00);
        convert("R5 neg zero", 32'h8000_0000, SEED_ZERO, 16'h8000);
        convert("R5 pos zero", 32'h0000_0000, SEED_ZERO, 16'h0000);
        convert("R6 overflow", 32'h5015_02F9, SEED_ZERO, 16'h7C00);
        convert("R6 neg overflow", 32'hD015_02F9, SEED_BIG, 16'hFC00);
    endtask

    task automatic t_idle;
        convert("R1 before idle", 32'h4049_0FDB, SEED_BIG, 16'h4248);
        @(negedge clk);
        in_word = 32'h3F80_0000; in_seed = SEED_ZERO;
        check("R1 idle valid low", {31'b0, out_valid}, 32'd0);
        @(negedge clk);
        check("R2 idle hold", {16'b0, out_word}, 32'h0000_4248);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_lfsr();
        t_normal();
        t_ratio();
        t_carry();
        t_subnormal();
        t_special();
        t_idle();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule